// File: doc/BRIEF.md
# Board Interrupt Collector with Identity Registers

This block gathers up to sixteen level-sensitive interrupt sources from a peripheral board and folds them into one active-low interrupt line toward the host. Each source passes through a two-flop synchronizer. A rising edge on a source latches a pending bit in the status register. A mask register, in which a 1 blocks a source, filters the pending bits. The block holds its interrupt output low while any pending bit is not blocked.

Host software reaches the block through a simple synchronous 16-bit register bus with word offsets. A clear register removes pending bits: every bit written as 1 holds the matching status bit at zero until software writes the bit back to 0. Three constant signature words let software confirm that the board is fitted, and a version word reports the logic revision. The bus carries no data stream, so it has no valid/ready pair. A read is a single-cycle strobe, and the result is returned on the next cycle.

Top module: `brd_irq_hub`

## Requirements
- R1: After reset, the status register and the mask register both read 0x0000, and `irq_n` is high.
- R2: A rising edge on `src_in[n]` sets status bit n. The bit stays set after the source falls, until it is cleared through the clear register.
- R3: Writing the mask register (offset 0x1) stores the written value. A mask bit of 1 blocks source n from `irq_n`, and a bit of 0 lets it through. Status bits still latch and read back while masked.
- R4: `irq_n` is low exactly when (status AND NOT mask) is nonzero. It is registered, so it follows a status or mask change one clock later.
- R5: The clear register (offset 0x2) holds its written value and reads it back. While bit n of it is 1, status bit n is forced to 0 from the next clock on, and a new source edge in that time is lost. Writing 0 releases the clear.
- R6: Offsets 0x3, 0x4 and 0x5 read the constants 0xAAAA, 0x5555 and 0xCAFE respectively.
- R7: Offset 0x6 reads the version parameter (default 0x0103).
- R8: Offset 0x7 reads 0x0000. Writes to offsets 0x3 to 0x7 change no register.
- R9: `bus_rdata` takes the value of the register selected when `bus_rd` is high at a clock edge. It holds that value until the next read.
- R10: Sources pass two synchronizer flops before edge detection. A source that rises before edge E0 shows in a read strobed at edge E3 and not in one strobed at E2. It drives `irq_n` low after E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | 16 | Asynchronous interrupt sources, bit n is source n |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| irq_n | output | 1 | Combined interrupt, active low, level |

## Verification
The bench reads status while the clear register is still held and pulses a source in that window. A design in which a fresh edge beats the clear would report the bit as pending. It unmasks a bit that is already pending and samples `irq_n` on both sides of the register stage. A combinational output, or one delayed by two stages, would be caught on the wrong side. It strobes status reads on consecutive edges after a source rises, which exposes a synchronizer that is one flop short or one flop long. It writes into signature and version offsets and reads them back, so decoding that lets such a write reach the mask or clear register shows up.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_ID0  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_ID1  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_ID2  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_VER  = 3'd6;

  localparam logic [REG_W-1:0] ID_WORD0 = 16'hAAAA;
  localparam logic [REG_W-1:0] ID_WORD1 = 16'h5555;
  localparam logic [REG_W-1:0] ID_WORD2 = 16'hCAFE;
endpackage

// File: rtl/brd_irq_sync.sv
module brd_irq_sync #(
  parameter int NUM_SRC = 16,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_async,
  output logic [NUM_SRC-1:0] rise
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk) begin
      if (rst) pipe_q <= '0;
      else     pipe_q <= {pipe_q[STAGES-1:0], src_async[i]};
    end
    assign rise[i] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end
endmodule

// File: rtl/brd_irq_status.sv
module brd_irq_status #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] clr_hold,
  output logic [NUM_SRC-1:0] status
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)              status[i] <= 1'b0;
      else if (clr_hold[i]) status[i] <= 1'b0;
      else if (rise[i])     status[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/brd_irq_regs.sv
module brd_irq_regs
  import brd_irq_pkg::*;
#(
  parameter int               NUM_SRC = 16,
  parameter logic [REG_W-1:0] VERSION = 16'h0103
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic               bus_rd,
  input  logic [NUM_SRC-1:0] status,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] clr_q,
  output logic [REG_W-1:0]   rdata_q
);
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      clr_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_MASK) mask_q <= bus_wdata[NUM_SRC-1:0];
      if (bus_addr == OFS_CLR)  clr_q  <= bus_wdata[NUM_SRC-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_STAT: rd_mux[NUM_SRC-1:0] = status;
      OFS_MASK: rd_mux[NUM_SRC-1:0] = mask_q;
      OFS_CLR:  rd_mux[NUM_SRC-1:0] = clr_q;
      OFS_ID0:  rd_mux = ID_WORD0;
      OFS_ID1:  rd_mux = ID_WORD1;
      OFS_ID2:  rd_mux = ID_WORD2;
      OFS_VER:  rd_mux = VERSION;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
endmodule

// File: rtl/brd_irq_hub.sv
module brd_irq_hub
  import brd_irq_pkg::*;
#(
  parameter int               NUM_SRC = 16,
  parameter logic [REG_W-1:0] VERSION = 16'h0103
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [REG_W-1:0]   bus_wdata,
  input  logic               bus_rd,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq_n
);
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] status_w;
  logic [NUM_SRC-1:0] mask_w;
  logic [NUM_SRC-1:0] clr_w;

  brd_irq_sync #(.NUM_SRC(NUM_SRC), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .src_async(src_in), .rise(rise_w)
  );

  brd_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk(clk), .rst(rst), .rise(rise_w), .clr_hold(clr_w), .status(status_w)
  );

  brd_irq_regs #(.NUM_SRC(NUM_SRC), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .status(status_w),
    .mask_q(mask_w), .clr_q(clr_w), .rdata_q(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(status_w & ~mask_w);
  end
endmodule

// File: rtl/brd_irq_hub_chk.sv
module brd_irq_hub_chk
  import brd_irq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [REG_W-1:0]   bus_wdata,
  input logic               irq_n,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] clr_q
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (status_q == '0 && mask_q == '0 && irq_n));

  assert_latch_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    ((status_q & $past(status_q & ~clr_q)) == $past(status_q & ~clr_q)));

  assert_mask_store_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_MASK) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(|(status_q & ~mask_q)));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (|clr_q) |=> ((status_q & $past(clr_q)) == '0));

  assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr >= OFS_ID0) |=> ($stable(mask_q) && $stable(clr_q)));
endmodule

bind brd_irq_hub brd_irq_hub_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .irq_n(irq_n), .status_q(status_w),
  .mask_q(mask_w), .clr_q(clr_w)
);

// File: tb/brd_irq_hub_tb_top.sv
`timescale 1ns/1ps
module brd_irq_hub_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_in = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        irq_n;

  int checks = 0;
  int errors = 0;
  logic rd_seen = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  brd_irq_hub dut_i (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result the cycle after its strobe (R9)
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected read", bus_rdata, 0);
      else begin
        automatic int    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata == e[15:0], t, bus_rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input int exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    check(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
    do_read(3'd0, 16'h0000, "R1 status after reset");
    do_read(3'd1, 16'h0000, "R1 mask after reset");

    do_read(3'd3, 16'hAAAA, "R6 id word 0");
    do_read(3'd4, 16'h5555, "R6 id word 1");
    do_read(3'd5, 16'hCAFE, "R6 id word 2");
    do_read(3'd6, 16'h0103, "R7 version");
    do_read(3'd7, 16'h0000, "R8 unmapped offset");
    bus_write(3'd3, 16'h1234);
    bus_write(3'd6, 16'hFFFF);
    bus_write(3'd7, 16'hFFFF);
    do_read(3'd3, 16'hAAAA, "R8 id write ignored");
    do_read(3'd6, 16'h0103, "R8 version write ignored");
    do_read(3'd1, 16'h0000, "R8 mask untouched by ro write");
    do_read(3'd2, 16'h0000, "R8 clear untouched by ro write");

    // R2: edge latches, survives source fall
    src_in[0] = 1'b1;
    wait_cyc(5);
    do_read(3'd0, 16'h0001, "R2 status set by edge");
    check(irq_n == 1'b0, "R4 irq asserted on pending", irq_n, 0);
    src_in[0] = 1'b0;
    wait_cyc(5);
    do_read(3'd0, 16'h0001, "R2 status latched after fall");
    wait_cyc(1);
    check(bus_rdata == 16'h0001, "R9 rdata holds between reads", bus_rdata, 16'h0001);

    // R3: masking
    bus_write(3'd1, 16'h0001);
    wait_cyc(2);
    check(irq_n == 1'b1, "R3 masked source releases irq", irq_n, 1);
    do_read(3'd0, 16'h0001, "R3 status kept while masked");
    do_read(3'd1, 16'h0001, "R3 mask readback");
    bus_write(3'd1, 16'h0000);
    check(irq_n == 1'b1, "R4 irq one clock behind unmask", irq_n, 1);
    wait_cyc(1);
    check(irq_n == 1'b0, "R4 irq after unmask", irq_n, 0);

    // R5: held clear
    bus_write(3'd2, 16'h0001);
    wait_cyc(2);
    do_read(3'd0, 16'h0000, "R5 status cleared");
    do_read(3'd2, 16'h0001, "R5 clear readback");
    check(irq_n == 1'b1, "R5 irq released by clear", irq_n, 1);
    src_in[0] = 1'b1; wait_cyc(5); src_in[0] = 1'b0; wait_cyc(5);
    do_read(3'd0, 16'h0000, "R5 held clear beats new edge");
    bus_write(3'd2, 16'h0000);
    wait_cyc(2);
    do_read(3'd0, 16'h0000, "R5 lost edge not remembered");

    // R10: synchronizer latency
    src_in[5] = 1'b1;
    do_read(3'd0, 16'h0000, "R10 read at E0");
    do_read(3'd0, 16'h0000, "R10 read at E1");
    do_read(3'd0, 16'h0000, "R10 read at E2");
    check(irq_n == 1'b1, "R10 irq still high after E2", irq_n, 1);
    do_read(3'd0, 16'h0020, "R10 read at E3");
    check(irq_n == 1'b0, "R10 irq low after E3", irq_n, 0);

    bus_write(3'd2, 16'hFFFF);
    bus_write(3'd2, 16'h0000);
    wait_cyc(2);
    do_read(3'd0, 16'h0000, "R5 clear all");

    // R2/R4: multiple sources, level held
    src_in[3] = 1'b1; src_in[15] = 1'b1;
    wait_cyc(5);
    do_read(3'd0, 16'h8008, "R2 two sources latched");
    check(irq_n == 1'b0, "R4 irq with two pending", irq_n, 0);
    bus_write(3'd1, 16'h0008);
    wait_cyc(2);
    check(irq_n == 1'b0, "R3 one masked one open", irq_n, 0);
    bus_write(3'd1, 16'h8008);
    wait_cyc(2);
    check(irq_n == 1'b1, "R3 both masked", irq_n, 1);
    bus_write(3'd1, 16'h0000);
    bus_write(3'd2, 16'hFFFF);
    bus_write(3'd2, 16'h0000);
    wait_cyc(3);
    check(irq_n == 1'b1, "R5 irq high after full clear", irq_n, 1);
    do_read(3'd0, 16'h0000, "R2 held level sets no new bit");

    wait_cyc(2);
    check(exp_q.size() == 0, "R9 all reads returned", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule